// File: doc/BRIEF.md
# CPU Clock Divider and Power-Down Sequencer

This block sits between a free-running oscillator clock and the processor core of a small microcontroller. It divides the oscillator clock by 4, 8 or 64 to make the CPU clock. It brings out a one-cycle tick that marks the end of each CPU clock period. It keeps a peripheral clock enable that drops only when the oscillator is halted.

The core can request two sleep depths. In the shallow one, only the CPU clock stops; the peripherals and the oscillator keep running, and a qualifying interrupt resumes execution on the next oscillator edge. In the deep one, the oscillator is halted. A qualifying interrupt first restarts it, and the CPU stays halted for a programmable settling count before it runs. Reset always passes through the same settling state, with a fixed count of 2^RST_LOG2 oscillator cycles. One interrupt input, selected by a parameter, can never end either sleep mode. A two-bit mode code reports where the sequencer stands.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: The CPU clock period is 4, 8 or 64 oscillator cycles for `div_sel` codes 0, 1 and 2; code 3 also gives 64. `cpu_tick` is high for exactly one oscillator cycle, the last of each CPU period. `cpu_clk` is high for the first half of each period.
- R2: A new `div_sel` value takes effect only when the CPU period in progress ends. That period completes with the old divisor.
- R3: While `rst_n` is low, and for 2^RST_LOG2 oscillator cycles after it rises, `mode_code` reads 3 (settling) and no `cpu_tick` occurs. After that, `mode_code` reads 0 (run).
- R4: A one-cycle `idle_cmd` in run mode with no wake request pending moves `mode_code` to 1 (idle) on the next edge. The CPU clock stops once its current period ends, and `periph_en` stays 1.
- R5: A one-cycle `stop_cmd` in run mode with no wake request pending moves `mode_code` to 2 (stop) on the next edge. Once the current CPU period ends, `periph_en` falls to 0 and no `cpu_tick` occurs. When both commands arrive in the same cycle, stop wins.
- R6: A wake request is any bit `i` with `irq_req[i]` and `irq_en[i]` both 1 and `i` not equal to BARRED_IDX (default 0). In idle, a wake request moves `mode_code` to 0 on the next edge, and ticks resume.
- R7: In stop, a wake request moves `mode_code` to 3 on the next edge and raises `periph_en`. The settling state lasts 2^(WAKE_BASE_LOG2 + 2*`stab_sel`) cycles, using the `stab_sel` value sampled on that edge, and then `mode_code` returns to 0. Requests arriving during settling have no effect.
- R8: A request at index BARRED_IDX, or a request whose enable bit is 0, never ends idle or stop.
- R9: Idle and stop commands are ignored while a wake request is pending, and ticks continue. They are also ignored in any mode other than run.
- R10: Asserting `rst_n` low forces `mode_code` to 3 at once from any mode, with `periph_en` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | CPU clock divide code from the power control register |
| stab_sel | input | 2 | Settling-length code used on wake from stop |
| idle_cmd | input | 1 | One-cycle request to enter idle |
| stop_cmd | input | 1 | One-cycle request to enter stop |
| irq_req | input | NIRQ | Interrupt request flags |
| irq_en | input | NIRQ | Interrupt enable flags |
| cpu_clk | output | 1 | Gated, divided CPU clock |
| cpu_tick | output | 1 | One-cycle marker of the last oscillator cycle of a CPU period |
| periph_en | output | 1 | Peripheral clock enable, 0 while the oscillator is halted |
| mode_code | output | 2 | 0 run, 1 idle, 2 stop, 3 settling |

## Verification
Mode changes on command or wake appear one oscillator edge after the input is presented. The bench drives inputs on falling edges and reads `mode_code` on the next falling edge. Settling after reset or deep-sleep wake is counted exactly: the bench waits one cycle fewer than the expected length, checks that the code is still 3, and then checks for run one cycle later. Tick-related results are due only at CPU period boundaries, so the bench measures the gap between successive ticks in oscillator cycles and compares it once enough ticks have passed for a divide change to settle. The boundary rule is checked by changing the divide code one cycle into a period and expecting the old gap, then the new one.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  // counter width of the CPU clock divider; must hold the largest divisor - 1
  localparam int DIV_CW = 6;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_STOP = 2'd2,
    MODE_STAB = 2'd3
  } pdc_mode_e;

  // last count value of one CPU period for a divide code
  function automatic logic [DIV_CW-1:0] div_last(input logic [1:0] sel);
    case (sel)
      2'd0:    return DIV_CW'(3);
      2'd1:    return DIV_CW'(7);
      default: return DIV_CW'(63);
    endcase
  endfunction

  // number of counts in the high phase of the CPU clock
  function automatic logic [DIV_CW-1:0] div_half(input logic [1:0] sel);
    case (sel)
      2'd0:    return DIV_CW'(2);
      2'd1:    return DIV_CW'(4);
      default: return DIV_CW'(32);
    endcase
  endfunction

endpackage

// File: rtl/pdc_clk_div.sv
module pdc_clk_div
  import pdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  input  logic       run_now,
  input  logic       halt,
  output logic       cpu_clk,
  output logic       cpu_tick,
  output logic       gate
);

  logic [DIV_CW-1:0] cnt_q;
  logic [DIV_CW-1:0] last_w;
  logic [1:0]        act_sel_q;
  logic              gate_q;
  logic              wrap_w;

  assign last_w = div_last(act_sel_q);
  assign wrap_w = (cnt_q == last_w);

  // divide code and gate are both latched only on the wrap, so every
  // CPU clock pulse is a whole period of one divisor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      act_sel_q <= 2'd0;
      gate_q    <= 1'b0;
    end else if (!halt) begin
      if (wrap_w) begin
        cnt_q     <= '0;
        act_sel_q <= div_sel;
        gate_q    <= run_now;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cpu_clk  = gate_q & (cnt_q < div_half(act_sel_q));
  assign cpu_tick = gate_q & wrap_w;
  assign gate     = gate_q;

  // R2: the active divide code changes only right after a period end
  p_sel_on_boundary_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (act_sel_q != $past(act_sel_q)) |-> $past(wrap_w));

  // R5: with the oscillator halted the divider does not move
  p_frozen_in_halt_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(cnt_q));

endmodule

// File: rtl/pdc_wake_qual.sv
module pdc_wake_qual #(
  parameter int NIRQ       = 7,
  parameter int BARRED_IDX = 0
) (
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output logic            wake_pend,
  output logic            barred_pend
);

  logic [NIRQ-1:0] cand;

  generate
    for (genvar i = 0; i < NIRQ; i++) begin : g_src
      if (i == BARRED_IDX) begin : g_barred
        assign cand[i] = 1'b0;
      end else begin : g_open
        assign cand[i] = irq_req[i] & irq_en[i];
      end
    end
  endgenerate

  assign wake_pend   = |cand;
  assign barred_pend = irq_req[BARRED_IDX] & irq_en[BARRED_IDX];

endmodule

// File: rtl/pdc_stab_timer.sv
module pdc_stab_timer #(
  parameter int CW        = 18,
  parameter int RST_LOG2  = 17,
  parameter int WAKE_BASE = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] stab_sel,
  input  logic       count_en,
  output logic       done
);

  function automatic logic [CW-1:0] last_of(input int unsigned lg);
    logic [CW-1:0] one;
    one    = '0;
    one[0] = 1'b1;
    return (one << lg) - one;
  endfunction

  localparam logic [CW-1:0] RST_LAST = last_of(RST_LOG2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] wake_last;

  always_comb wake_last = last_of(WAKE_BASE + 2 * int'(stab_sel));

  assign done = count_en & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_LAST;
    end else if (load) begin
      cnt_q <= wake_last;
    end else if (count_en && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7: each settling cycle short of the end removes exactly one count
  p_countdown_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !done && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pdc_mode_fsm.sv
module pdc_mode_fsm
  import pdc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idle_cmd,
  input  logic      stop_cmd,
  input  logic      wake_pend,
  input  logic      stab_done,
  output pdc_mode_e mode,
  output logic      stab_load
);

  pdc_mode_e st_q;
  pdc_mode_e st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      MODE_RUN: begin
        if (!wake_pend) begin
          if (stop_cmd)      st_d = MODE_STOP;
          else if (idle_cmd) st_d = MODE_IDLE;
        end
      end
      MODE_IDLE: if (wake_pend) st_d = MODE_RUN;
      MODE_STOP: if (wake_pend) st_d = MODE_STAB;
      MODE_STAB: if (stab_done) st_d = MODE_RUN;
      default:   st_d = MODE_STAB;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= MODE_STAB;
    else        st_q <= st_d;
  end

  assign mode      = st_q;
  assign stab_load = (st_q == MODE_STOP) & wake_pend;

  // R5: stop is only ever entered from an accepted stop command
  p_stop_entry_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MODE_STOP) && ($past(st_q) != MODE_STOP)) |->
      ($past(stop_cmd) && !$past(wake_pend)));

  // R6: a wake request ends idle on the very next edge
  p_idle_wake_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MODE_IDLE) && wake_pend) |=> (st_q == MODE_RUN));

  // R8: without a wake request stop is held
  p_stop_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MODE_STOP) && !wake_pend) |=> (st_q == MODE_STOP));

  // R9: a pending wake request keeps the core running
  p_cmd_blocked_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MODE_RUN) && wake_pend) |=> (st_q == MODE_RUN));

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pdc_pkg::*;
#(
  parameter int NIRQ           = 7,
  parameter int BARRED_IDX     = 0,
  parameter int RST_LOG2       = 17,
  parameter int WAKE_BASE_LOG2 = 10
) (
  input  logic            osc_clk,
  input  logic            rst_n,
  input  logic [1:0]      div_sel,
  input  logic [1:0]      stab_sel,
  input  logic            idle_cmd,
  input  logic            stop_cmd,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output logic            cpu_clk,
  output logic            cpu_tick,
  output logic            periph_en,
  output logic [1:0]      mode_code
);

  localparam int WAKE_MAX_LOG2 = WAKE_BASE_LOG2 + 6;
  localparam int STAB_CW =
    ((RST_LOG2 > WAKE_MAX_LOG2) ? RST_LOG2 : WAKE_MAX_LOG2) + 1;

  pdc_mode_e mode;
  logic      wake_pend;
  logic      barred_pend;
  logic      stab_done;
  logic      stab_load;
  logic      run_now;
  logic      halt;
  logic      gate;

  pdc_wake_qual #(
    .NIRQ       (NIRQ),
    .BARRED_IDX (BARRED_IDX)
  ) u_wake (
    .irq_req     (irq_req),
    .irq_en      (irq_en),
    .wake_pend   (wake_pend),
    .barred_pend (barred_pend)
  );

  pdc_mode_fsm u_fsm (
    .clk       (osc_clk),
    .rst_n     (rst_n),
    .idle_cmd  (idle_cmd),
    .stop_cmd  (stop_cmd),
    .wake_pend (wake_pend),
    .stab_done (stab_done),
    .mode      (mode),
    .stab_load (stab_load)
  );

  pdc_stab_timer #(
    .CW        (STAB_CW),
    .RST_LOG2  (RST_LOG2),
    .WAKE_BASE (WAKE_BASE_LOG2)
  ) u_stab (
    .clk      (osc_clk),
    .rst_n    (rst_n),
    .load     (stab_load),
    .stab_sel (stab_sel),
    .count_en (mode == MODE_STAB),
    .done     (stab_done)
  );

  assign run_now = (mode == MODE_RUN);
  // the oscillator halts only after the last CPU pulse has completed
  assign halt    = (mode == MODE_STOP) & ~gate;

  pdc_clk_div u_div (
    .clk      (osc_clk),
    .rst_n    (rst_n),
    .div_sel  (div_sel),
    .run_now  (run_now),
    .halt     (halt),
    .cpu_clk  (cpu_clk),
    .cpu_tick (cpu_tick),
    .gate     (gate)
  );

  assign periph_en = ~halt;
  assign mode_code = mode;

  // R8: the barred source alone never ends idle
  p_barred_no_wake_r8 : assert property (@(posedge osc_clk) disable iff (!rst_n)
    ((mode == MODE_IDLE) && barred_pend && !wake_pend) |=> (mode == MODE_IDLE));

  // R3: the CPU clock never ticks while settling with the gate shut
  p_quiet_settle_r3 : assert property (@(posedge osc_clk) disable iff (!rst_n)
    ((mode == MODE_STAB) && !gate) |=> !cpu_tick);

endmodule

// File: tb/sim_pwr_clk_ctrl.sv
module sim_pwr_clk_ctrl;

  localparam int NIRQ      = 5;
  localparam int RST_LOG2  = 6;
  localparam int WAKE_BASE = 2;
  localparam int RST_WAIT  = 1 << RST_LOG2;

  // divide code, expected tick gap in oscillator cycles (R1)
  localparam logic [8:0] DIV_VEC [0:5] = '{
    {2'd1, 7'd8}, {2'd2, 7'd64}, {2'd0, 7'd4},
    {2'd3, 7'd64}, {2'd1, 7'd8}, {2'd0, 7'd4}
  };

  logic            osc_clk  = 1'b0;
  logic            rst_n    = 1'b0;
  logic [1:0]      div_sel  = 2'd0;
  logic [1:0]      stab_sel = 2'd0;
  logic            idle_cmd = 1'b0;
  logic            stop_cmd = 1'b0;
  logic [NIRQ-1:0] irq_req  = '0;
  logic [NIRQ-1:0] irq_en   = '1;
  wire             cpu_clk, cpu_tick, periph_en;
  wire  [1:0]      mode_code;

  pwr_clk_ctrl #(
    .NIRQ (NIRQ), .BARRED_IDX (0), .RST_LOG2 (RST_LOG2), .WAKE_BASE_LOG2 (WAKE_BASE)
  ) u0 (
    .osc_clk (osc_clk), .rst_n (rst_n), .div_sel (div_sel), .stab_sel (stab_sel),
    .idle_cmd (idle_cmd), .stop_cmd (stop_cmd), .irq_req (irq_req), .irq_en (irq_en),
    .cpu_clk (cpu_clk), .cpu_tick (cpu_tick), .periph_en (periph_en), .mode_code (mode_code)
  );

  always #2 osc_clk = ~osc_clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, tick_cnt = 0, gap = 0, last_t = 0;
  bit done = 1'b0;

  always @(posedge osc_clk) cyc <= cyc + 1;

  always @(negedge osc_clk)
    if (rst_n && cpu_tick) begin
      tick_cnt <= tick_cnt + 1;
      gap      <= cyc - last_t;
      last_t   <= cyc;
    end

  function automatic int exp_gap(input logic [1:0] s);
    int g;
    g = 4;
    for (int i = 0; i < int'(s) && i < 2; i++) g = (i == 0) ? 8 : 64;
    return g;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge osc_clk);
  endtask

  task automatic pulse(input bit i, input bit s);
    @(negedge osc_clk); idle_cmd = i; stop_cmd = s;
    @(negedge osc_clk); idle_cmd = 1'b0; stop_cmd = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    int target;
    target = tick_cnt + n;
    while (tick_cnt < target) begin
      @(negedge osc_clk); #1;
    end
  endtask

  task automatic settle_after_reset(input string tag);
    int t0;
    @(negedge osc_clk); rst_n = 1'b1;
    t0 = tick_cnt;
    repeat (RST_WAIT - 1) @(negedge osc_clk);
    chk(mode_code == 2'd3, {tag, " R3 still settling"}, mode_code, 3);
    @(negedge osc_clk);
    chk(mode_code == 2'd0, {tag, " R3 run after wait"}, mode_code, 0);
    #1;
    chk(tick_cnt == t0, {tag, " R3 no ticks while settling"}, tick_cnt - t0, 0);
  endtask

  initial begin
    #(20000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int t0, hi;
    // reset state
    step(4);
    chk(mode_code == 2'd3, "R10 mode in reset", mode_code, 3);
    chk(cpu_tick == 1'b0 && cpu_clk == 1'b0, "R3 clock quiet in reset", cpu_clk, 0);
    chk(periph_en == 1'b1, "R10 periph_en in reset", periph_en, 1);
    settle_after_reset("first");

    // R1: divide table, gap and high phase
    for (int k = 0; k < 6; k++) begin
      div_sel = DIV_VEC[k][8:7];
      wait_ticks(3);
      chk(gap == int'(DIV_VEC[k][6:0]), "R1 tick gap", gap, DIV_VEC[k][6:0]);
      chk(gap == exp_gap(div_sel), "R1 tick gap by rule", gap, exp_gap(div_sel));
      hi = 0;
      do begin
        @(negedge osc_clk);
        if (cpu_clk) hi++;
      end while (!cpu_tick);
      chk(hi == int'(DIV_VEC[k][6:0]) / 2, "R1 high phase", hi, DIV_VEC[k][6:0] / 2);
    end

    // R2: change one cycle into a divide-by-4 period
    wait_ticks(1);
    @(negedge osc_clk); div_sel = 2'd2;
    wait_ticks(1);
    chk(gap == 4, "R2 period in progress keeps old divisor", gap, 4);
    wait_ticks(1);
    chk(gap == 64, "R2 next period uses new divisor", gap, 64);
    div_sel = 2'd0;
    wait_ticks(3);

    // R4: idle entry
    pulse(1'b1, 1'b0);
    chk(mode_code == 2'd1, "R4 idle entered", mode_code, 1);
    step(10); #1; t0 = tick_cnt;
    step(50); #1;
    chk(tick_cnt == t0, "R4 no ticks in idle", tick_cnt - t0, 0);
    chk(periph_en == 1'b1, "R4 periph_en in idle", periph_en, 1);
    pulse(1'b0, 1'b1);
    chk(mode_code == 2'd1, "R9 stop ignored in idle", mode_code, 1);

    // R8: barred and masked sources
    irq_req[0] = 1'b1; step(10);
    chk(mode_code == 2'd1, "R8 barred source in idle", mode_code, 1);
    irq_req[0] = 1'b0; irq_en[2] = 1'b0; irq_req[2] = 1'b1; step(10);
    chk(mode_code == 2'd1, "R8 masked source in idle", mode_code, 1);
    irq_req[2] = 1'b0; irq_en[2] = 1'b1;

    // R6: wake from idle
    @(negedge osc_clk); irq_req[1] = 1'b1;
    @(negedge osc_clk);
    chk(mode_code == 2'd0, "R6 idle wake next edge", mode_code, 0);
    irq_req[1] = 1'b0;
    wait_ticks(2);
    chk(gap == 4, "R6 ticks resume", gap, 4);

    // R9: commands blocked by a pending request
    irq_req[3] = 1'b1;
    pulse(1'b1, 1'b0);
    chk(mode_code == 2'd0, "R9 idle blocked", mode_code, 0);
    pulse(1'b0, 1'b1);
    chk(mode_code == 2'd0, "R9 stop blocked", mode_code, 0);
    wait_ticks(2);
    chk(gap == 4, "R9 ticks continue", gap, 4);
    irq_req[3] = 1'b0;

    // R5: stop entry
    stab_sel = 2'd1;
    pulse(1'b0, 1'b1);
    chk(mode_code == 2'd2, "R5 stop entered", mode_code, 2);
    step(20); #1;
    chk(periph_en == 1'b0, "R5 periph_en low in stop", periph_en, 0);
    t0 = tick_cnt; step(40); #1;
    chk(tick_cnt == t0, "R5 no ticks in stop", tick_cnt - t0, 0);
    irq_req[0] = 1'b1; step(10);
    chk(mode_code == 2'd2, "R8 barred source in stop", mode_code, 2);
    irq_req[0] = 1'b0;

    // R7: wake from stop, 16-cycle settle, later stab_sel change ignored
    @(negedge osc_clk); irq_req[4] = 1'b1;
    @(negedge osc_clk);
    chk(mode_code == 2'd3, "R7 settling after stop wake", mode_code, 3);
    chk(periph_en == 1'b1, "R7 periph_en while settling", periph_en, 1);
    stab_sel = 2'd3;
    repeat (15) @(negedge osc_clk);
    chk(mode_code == 2'd3, "R7 still settling", mode_code, 3);
    @(negedge osc_clk);
    chk(mode_code == 2'd0, "R7 run after settle", mode_code, 0);
    irq_req[4] = 1'b0; stab_sel = 2'd0;
    wait_ticks(2);

    // R5: stop wins over idle; R7: shortest settle
    pulse(1'b1, 1'b1);
    chk(mode_code == 2'd2, "R5 stop wins over idle", mode_code, 2);
    step(20);
    @(negedge osc_clk); irq_req[2] = 1'b1;
    @(negedge osc_clk);
    chk(mode_code == 2'd3, "R7 settle start", mode_code, 3);
    repeat (3) @(negedge osc_clk);
    chk(mode_code == 2'd3, "R7 short settle holds", mode_code, 3);
    @(negedge osc_clk);
    chk(mode_code == 2'd0, "R7 short settle ends", mode_code, 0);
    irq_req[2] = 1'b0;

    // R10: reset from stop
    pulse(1'b0, 1'b1);
    chk(mode_code == 2'd2, "R10 stop before reset", mode_code, 2);
    step(20);
    @(negedge osc_clk); rst_n = 1'b0;
    #1;
    chk(mode_code == 2'd3, "R10 reset forces settling", mode_code, 3);
    chk(periph_en == 1'b1, "R10 periph_en after reset", periph_en, 1);
    step(3);
    settle_after_reset("second");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule